// File: doc/BRIEF.md
# Character Overlay Video Memory Controller

This block holds the character-cell buffer for an on-screen text overlay together with the small register set a host uses to describe and place it. The buffer is 32 columns by 16 rows of 16-bit cells. Each cell carries a character code in its upper byte and a colour attribute in its lower byte. The host fills the buffer through a cell write port that takes a linear cell index. A display pipeline fetches cells through a separate column/row read port, one clock after presenting the position.

A second host port reaches six registers:
- a read-only revision word;
- a read-only geometry word;
- a read/write visible-window size;
- read/write horizontal and vertical overlay origins;
- a read-only status word holding a sticky fault flag.

Cells that fall outside the configured window are blanked on the display port.

Two small state machines run the host side. The read responder has states RD_IDLE and RD_RESP. Its transitions are:
- RD_IDLE→RD_RESP on a read strobe;
- RD_RESP→RD_RESP on a further strobe;
- RD_RESP→RD_IDLE with no strobe.

The fault tracker has states ERR_CLEAR and ERR_SET. It moves ERR_CLEAR→ERR_SET on an out-of-range cell write, and ERR_SET only ever returns to itself until reset.

Top module: `osd_char_buffer`

## Requirements
- R1: After reset the registers read as follows, with unlisted bits zero:
  - offset 0 reads 102 (revision major × 100 + minor, with major 1 and minor 2);
  - offset 1 reads 0x1F0F (columns−1 in bits 13:8, rows−1 in bits 4:0);
  - offset 2 reads 0x1F0F;
  - offset 3 reads 0x007F;
  - offset 4 reads 0x005F;
  - offset 5 reads 0.
  During reset `reg_rvalid` and `disp_cell` are 0.
- R2: A read strobe at offset A gives `reg_rvalid` high in the following cycle, with `reg_rdata` holding the value the register had when the strobe was sampled. Offsets 6 and 7 read 0. Back-to-back strobes give back-to-back responses.
- R3: Writes to offsets 0, 1 and 5 have no effect on any register.
- R4: Offsets 2, 3 and 4 store all 16 written bits. Offset 2 holds the visible columns−1 in bits 15:8 and the visible rows−1 in bits 7:0.
- R5: A cell write with index below 512 stores the 16-bit word at that index. The display read of column c, row r returns the cell at index r×32+c on `disp_cell` one clock after the position is presented, with the character code in bits 15:8 and the attribute in bits 7:0.
- R6: A cell write with index 512 or above changes no cell, including the cell at index−512. It sets status bit 0, which stays set until reset.
- R7: The display port returns 0x0000 for column c or row r when c is greater than bits 15:8, or r is greater than bits 7:0, of the window register as it stood when the position was presented.
- R8: When a host cell write and a display read hit the same cell in one cycle, the display gets the old word. The next display read of that cell gets the new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read response, one cycle after reg_re |
| cell_we | input | 1 | Cell write strobe |
| cell_addr | input | 10 | Linear cell index (row × 32 + column) |
| cell_wdata | input | 16 | Cell word: character 15:8, attribute 7:0 |
| disp_col | input | 5 | Display fetch column |
| disp_row | input | 4 | Display fetch row |
| disp_cell | output | 16 | Fetched cell, one cycle after the position |

## Verification
The case that matters most is a host cell write and a display fetch landing on the same cell in the same clock. The bench provokes it by pointing the display port at the index being written in that cycle. It judges the result against a behavioural model that returns the pre-write word and then the new word on the following cycle. The same concern arises on the register side: a read and a write to the same register in one cycle must return the old value. Both orderings are compared on every clock, alongside window blanking computed from the window value the model held at that edge.

// File: rtl/osd_pkg.sv
package osd_pkg;
    localparam int WIN_W = 8;
    localparam int DW    = 16;

    localparam logic [2:0] OFS_REVISION = 3'd0;
    localparam logic [2:0] OFS_GEOMETRY = 3'd1;
    localparam logic [2:0] OFS_WINDOW   = 3'd2;
    localparam logic [2:0] OFS_ORIGIN_X = 3'd3;
    localparam logic [2:0] OFS_ORIGIN_Y = 3'd4;
    localparam logic [2:0] OFS_STATUS   = 3'd5;

    typedef enum logic {RD_IDLE, RD_RESP}    rd_state_e;
    typedef enum logic {ERR_CLEAR, ERR_SET}  err_state_e;
endpackage

// File: rtl/osd_cell_ram.sv
module osd_cell_ram #(
    parameter int DEPTH = 512,
    parameter int DW    = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // read-before-write: a same-cycle write is seen on the next read
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= mem[raddr];
    end
endmodule

// File: rtl/osd_host_regs.sv
module osd_host_regs
    import osd_pkg::*;
#(
    parameter int COLS      = 32,
    parameter int ROWS      = 16,
    parameter int VER_MAJOR = 1,
    parameter int VER_MINOR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_re,
    input  logic [2:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             reg_rvalid,
    input  logic             cell_fault,
    output logic [WIN_W-1:0] win_cols_m1,
    output logic [WIN_W-1:0] win_rows_m1
);
    localparam logic [DW-1:0] REVISION_V = DW'(VER_MAJOR * 100 + VER_MINOR);
    localparam logic [DW-1:0] GEOMETRY_V = {2'b00, 6'(COLS - 1), 3'b000, 5'(ROWS - 1)};
    localparam logic [DW-1:0] WINDOW_RST = {8'(COLS - 1), 8'(ROWS - 1)};
    localparam logic [DW-1:0] ORIGIN_X_RST = 16'h007F;
    localparam logic [DW-1:0] ORIGIN_Y_RST = 16'h005F;

    rd_state_e  rd_state, rd_next;
    err_state_e err_state, err_next;
    logic [DW-1:0] window_q, origin_x_q, origin_y_q, rdata_q, rd_mux;

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_state  <= RD_IDLE;
            err_state <= ERR_CLEAR;
        end else begin
            rd_state  <= rd_next;
            err_state <= err_next;
        end
    end

    always_comb begin
        unique case (rd_state)
            RD_IDLE: rd_next = reg_re ? RD_RESP : RD_IDLE;
            RD_RESP: rd_next = reg_re ? RD_RESP : RD_IDLE;
        endcase
        unique case (err_state)
            ERR_CLEAR: err_next = cell_fault ? ERR_SET : ERR_CLEAR;
            ERR_SET:   err_next = ERR_SET;
        endcase
    end

    always_comb begin
        unique case (reg_addr)
            OFS_REVISION: rd_mux = REVISION_V;
            OFS_GEOMETRY: rd_mux = GEOMETRY_V;
            OFS_WINDOW:   rd_mux = window_q;
            OFS_ORIGIN_X: rd_mux = origin_x_q;
            OFS_ORIGIN_Y: rd_mux = origin_y_q;
            OFS_STATUS:   rd_mux = {15'd0, err_state == ERR_SET};
            default:      rd_mux = '0;
        endcase
    end

    // output / register-file process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            window_q   <= WINDOW_RST;
            origin_x_q <= ORIGIN_X_RST;
            origin_y_q <= ORIGIN_Y_RST;
            rdata_q    <= '0;
        end else begin
            if (reg_re) rdata_q <= rd_mux;
            if (reg_we) begin
                if (reg_addr == OFS_WINDOW)   window_q   <= reg_wdata;
                if (reg_addr == OFS_ORIGIN_X) origin_x_q <= reg_wdata;
                if (reg_addr == OFS_ORIGIN_Y) origin_y_q <= reg_wdata;
            end
        end
    end

    assign reg_rdata   = rdata_q;
    assign reg_rvalid  = (rd_state == RD_RESP);
    assign win_cols_m1 = window_q[15:8];
    assign win_rows_m1 = window_q[7:0];

    p_rvalid_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> reg_rvalid);
    p_no_spurious_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |=> !reg_rvalid);
    p_fault_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cell_fault |=> (err_state == ERR_SET));
    p_fault_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_state == ERR_SET) |=> (err_state == ERR_SET));
    p_window_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(window_q));
endmodule

// File: rtl/osd_fetch.sv
module osd_fetch
    import osd_pkg::*;
#(
    parameter int COLS  = 32,
    parameter int ROWS  = 16,
    parameter int COL_W = $clog2(COLS),
    parameter int ROW_W = $clog2(ROWS),
    parameter int AW    = $clog2(COLS * ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [COL_W-1:0] disp_col,
    input  logic [ROW_W-1:0] disp_row,
    input  logic [WIN_W-1:0] win_cols_m1,
    input  logic [WIN_W-1:0] win_rows_m1,
    input  logic [DW-1:0]    ram_rdata,
    output logic [AW-1:0]    ram_raddr,
    output logic [DW-1:0]    disp_cell
);
    localparam logic [AW-1:0] COLS_V = AW'(COLS);

    logic outside, outside_q;

    assign ram_raddr = AW'(disp_row) * COLS_V + AW'(disp_col);
    assign outside   = (WIN_W'(disp_col) > win_cols_m1) || (WIN_W'(disp_row) > win_rows_m1);

    always_ff @(posedge clk) begin
        if (!rst_n) outside_q <= 1'b0;
        else        outside_q <= outside;
    end

    assign disp_cell = outside_q ? '0 : ram_rdata;

    p_outside_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        outside |=> (disp_cell == '0));
endmodule

// File: rtl/osd_char_buffer.sv
module osd_char_buffer
    import osd_pkg::*;
#(
    parameter int COLS      = 32,
    parameter int ROWS      = 16,
    parameter int CELL_AW   = 10,
    parameter int VER_MAJOR = 1,
    parameter int VER_MINOR = 2,
    parameter int COL_W     = $clog2(COLS),
    parameter int ROW_W     = $clog2(ROWS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic               reg_re,
    input  logic [2:0]         reg_addr,
    input  logic [15:0]        reg_wdata,
    output logic [15:0]        reg_rdata,
    output logic               reg_rvalid,
    input  logic               cell_we,
    input  logic [CELL_AW-1:0] cell_addr,
    input  logic [15:0]        cell_wdata,
    input  logic [COL_W-1:0]   disp_col,
    input  logic [ROW_W-1:0]   disp_row,
    output logic [15:0]        disp_cell
);
    localparam int DEPTH  = COLS * ROWS;
    localparam int RAM_AW = $clog2(DEPTH);

    logic             in_range, ram_we, cell_fault;
    logic [RAM_AW-1:0] ram_raddr;
    logic [DW-1:0]    ram_rdata;
    logic [WIN_W-1:0] win_cols_m1, win_rows_m1;

    assign in_range   = (cell_addr < CELL_AW'(DEPTH));
    assign ram_we     = cell_we && in_range;
    assign cell_fault = cell_we && !in_range;

    osd_host_regs #(
        .COLS(COLS), .ROWS(ROWS), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .cell_fault(cell_fault),
        .win_cols_m1(win_cols_m1), .win_rows_m1(win_rows_m1)
    );

    osd_cell_ram #(.DEPTH(DEPTH), .DW(DW), .AW(RAM_AW)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .we(ram_we), .waddr(cell_addr[RAM_AW-1:0]), .wdata(cell_wdata),
        .raddr(ram_raddr), .rdata(ram_rdata)
    );

    osd_fetch #(
        .COLS(COLS), .ROWS(ROWS), .COL_W(COL_W), .ROW_W(ROW_W), .AW(RAM_AW)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .disp_col(disp_col), .disp_row(disp_row),
        .win_cols_m1(win_cols_m1), .win_rows_m1(win_rows_m1),
        .ram_rdata(ram_rdata), .ram_raddr(ram_raddr), .disp_cell(disp_cell)
    );
endmodule

// File: tb/osd_char_buffer_bench.sv
module osd_char_buffer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        reg_rvalid;
    logic        cell_we = 1'b0;
    logic [9:0]  cell_addr = '0;
    logic [15:0] cell_wdata = '0;
    logic [4:0]  disp_col = '0;
    logic [3:0]  disp_row = '0;
    logic [15:0] disp_cell;

    always #5 clk = ~clk;

    osd_char_buffer u_osd_char_buffer (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .cell_we(cell_we), .cell_addr(cell_addr), .cell_wdata(cell_wdata),
        .disp_col(disp_col), .disp_row(disp_row), .disp_cell(disp_cell)
    );

    // behavioural reference state
    int          n_chk = 0, n_fail = 0;
    string       cur_req = "R1";
    int          mem_m [512];
    bit          known [512];
    logic [15:0] win_m = 16'h1F0F, xo_m = 16'h007F, yo_m = 16'h005F;
    bit          err_m = 1'b0;

    task automatic chk(input bit ok, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] reg_val(input int a);
        case (a)
            0: return 16'd102;
            1: return 16'h1F0F;
            2: return win_m;
            3: return xo_m;
            4: return yo_m;
            5: return {15'd0, err_m};
            default: return 16'h0000;
        endcase
    endfunction

    // one clock: model predicts from pre-edge state, then compare after the edge
    task automatic step();
        bit          e_rv = reg_re;
        logic [15:0] e_rd = reg_val(int'(reg_addr));
        int          c = int'(disp_col), r = int'(disp_row);
        bit          outside = (c > int'(win_m[15:8])) || (r > int'(win_m[7:0]));
        int          idx = r * 32 + c;
        bit          dk = outside || known[idx];
        logic [15:0] e_disp = outside ? 16'h0 : 16'(mem_m[idx]);
        if (reg_we) begin
            if (reg_addr == 3'd2) win_m = reg_wdata;
            if (reg_addr == 3'd3) xo_m  = reg_wdata;
            if (reg_addr == 3'd4) yo_m  = reg_wdata;
        end
        if (cell_we) begin
            if (cell_addr < 10'd512) begin
                mem_m[cell_addr] = int'(cell_wdata);
                known[cell_addr] = 1'b1;
            end else err_m = 1'b1;
        end
        @(posedge clk);
        #2;
        chk(reg_rvalid == e_rv, "rvalid", {15'd0, reg_rvalid}, {15'd0, e_rv});
        if (e_rv) chk(reg_rdata == e_rd, "rdata", reg_rdata, e_rd);
        if (dk) chk(disp_cell == e_disp, "disp_cell", disp_cell, e_disp);
        reg_we = 1'b0; reg_re = 1'b0; cell_we = 1'b0;
    endtask

    task automatic rd(input int a);
        reg_re = 1'b1; reg_addr = 3'(a); step();
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d; step();
    endtask

    task automatic sweep();
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 32; c++) begin
                disp_col = 5'(c); disp_row = 4'(r); step();
            end
    endtask

    initial begin
        // R1: reset state of outputs
        cur_req = "R1";
        repeat (2) @(posedge clk);
        #2;
        chk(reg_rvalid == 1'b0, "rvalid in reset", {15'd0, reg_rvalid}, 16'h0);
        chk(disp_cell == 16'h0, "disp in reset", disp_cell, 16'h0);
        rst_n = 1'b1;
        for (int a = 0; a < 6; a++) rd(a);

        // R5: fill, display trailing the write pointer by one cell
        cur_req = "R5";
        for (int i = 0; i < 512; i++) begin
            cell_we = 1'b1; cell_addr = 10'(i);
            cell_wdata = {8'((i * 7 + 3) & 8'hFF), 8'(i ^ 8'h5A)};
            disp_col = 5'((i + 511) % 32); disp_row = 4'(((i + 511) % 512) / 32);
            step();
        end
        sweep();

        // R2: unmapped offsets and back-to-back reads
        cur_req = "R2";
        rd(6); rd(7); rd(2); rd(3); rd(4);

        // R3: read-only offsets ignore writes
        cur_req = "R3";
        wr(0, 16'hFFFF); wr(1, 16'h0000); wr(5, 16'hFFFF);
        rd(0); rd(1); rd(5);

        // R4: writable registers keep all bits; same-cycle read sees old value
        cur_req = "R4";
        wr(3, 16'h1234); wr(4, 16'hBEEF);
        reg_we = 1'b1; reg_re = 1'b1; reg_addr = 3'd2; reg_wdata = 16'h0A05; step();
        rd(2); rd(3); rd(4);

        // R7: window 11x6 blanks the rest, boundaries col 10/11 and row 5/6
        cur_req = "R7";
        sweep();
        disp_col = 5'd10; disp_row = 4'd5; step();
        disp_col = 5'd11; disp_row = 4'd5; step();
        disp_col = 5'd10; disp_row = 4'd6; step();
        wr(2, 16'h1F0F);

        // R6: out-of-range writes, no aliasing, sticky fault
        cur_req = "R6";
        rd(5);
        cell_we = 1'b1; cell_addr = 10'd515; cell_wdata = 16'hDEAD; step();
        cell_we = 1'b1; cell_addr = 10'd1023; cell_wdata = 16'hBEEF; step();
        disp_col = 5'd3; disp_row = 4'd0; step(); step();
        disp_col = 5'd31; disp_row = 4'd15; step(); step();
        rd(5);
        cell_we = 1'b1; cell_addr = 10'd7; cell_wdata = 16'h4142; step();
        rd(5); rd(5);

        // R8: same-cycle host write and display fetch of one cell
        cur_req = "R8";
        disp_col = 5'd8; disp_row = 4'd1;
        cell_we = 1'b1; cell_addr = 10'd40; cell_wdata = 16'h7E21; step();
        step(); step();
        disp_col = 5'd0; disp_row = 4'd15;
        cell_we = 1'b1; cell_addr = 10'd480; cell_wdata = 16'h3377; step();
        step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule